// File: doc/BRIEF.md
# Striped Block Request Splitter

This block takes one byte-addressed transfer request at a time and turns it into a stream of per-block command descriptors for a set of target channels. A request is a start address, a byte length and an operation: read, write, discard or rebuilding read. The block cuts the request at every 4096-byte block boundary. For each piece it works out which target channel owns the piece under stripe interleaving, the block address inside that target, and where the piece sits inside its block in 512-byte sectors.

Stripe size and the number of targets are configuration inputs. Both are sampled when a request is accepted. The target count is given as its base-two logarithm, so it is always a power of two. A stripe size that is not a power of two, or a target count above the supported maximum, makes the block reject the request. Descriptors leave on a valid/ready stream, one per clock while the consumer is ready. The request input stays blocked until the final piece of the current request has been handed off.

Top module: `striped_req_splitter`

## Requirements
- R1: The descriptor command byte is 0xC0 for a read (req_op 0), 0x80 for a write (req_op 1), 0x70 for a discard (req_op 2) and 0xE0 for a rebuilding read (req_op 3).
- R2: Read and write pieces are min(remaining, 4096 − (address mod 4096)) bytes long. Address and remaining length advance by the piece length until nothing remains. dsc_last marks the final piece. The low nine bits of req_addr and req_len are taken as zero.
- R3: For data pieces, dsc_sub bits [2:0] hold (address mod 4096)/512 and bits [6:4] hold piece length/512, where 0 stands for a full 4096-byte block. Bits 7 and 3 are zero.
- R4: Discard pieces are min(remaining, 4096) bytes long whatever the start offset, and dsc_sub is 0.
- R5: dsc_tgt equals (address >> log2(stripe)) masked with (2^cfg_tgt_log2 − 1).
- R6: dsc_lba equals (((address >> cfg_tgt_log2) & ~(stripe − 1)) | (address & (stripe − 1))) >> 12.
- R7: If the stripe size is zero or not a power of two, or cfg_tgt_log2 is above MAX_TGT_LOG, the accepted request produces no descriptors. req_err is then high for exactly the one cycle after acceptance.
- R8: req_ready is low from the acceptance of a non-empty valid request until the cycle after its last descriptor is handed off. A zero-length request is accepted and produces no descriptors and no error.
- R9: While dsc_valid is high and dsc_ready is low, all descriptor fields hold. While dsc_ready stays high, one descriptor is handed off per cycle.
- R10: Configuration is sampled at acceptance. Changing it while a request is being split has no effect on that request's descriptors.
- R11: After reset, req_ready is 1 and dsc_valid and req_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_stripe_bytes | input | ADDR_W | Stripe size in bytes, must be a power of two |
| cfg_tgt_log2 | input | TLOG_W | Base-two logarithm of the target count |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Length in bytes |
| req_op | input | 2 | 0 read, 1 write, 2 discard, 3 rebuilding read |
| req_err | output | 1 | One-cycle pulse: last accepted request was rejected |
| dsc_valid | output | 1 | Descriptor present |
| dsc_ready | input | 1 | Consumer takes the descriptor |
| dsc_tgt | output | TGT_W | Target channel index |
| dsc_lba | output | LBA_W | Block address within the target |
| dsc_cmd | output | 8 | Command byte |
| dsc_sub | output | 8 | Sector count in [6:4], sector offset in [2:0] |
| dsc_last | output | 1 | Final descriptor of the request |

## Verification
Two events can land in the same cycle: the consumer stalls the stream, and the configuration inputs change under a request that is still being split. The bench creates both together. It scrambles stripe size and target count right after every acceptance, and on alternate vectors it drops dsc_ready every other cycle. Every descriptor, stalled or not, is then compared with a model driven by the configuration sampled at acceptance. A repeated value after a stall is also compared with the value shown before the stall.

// File: rtl/splt_pkg.sv
package splt_pkg;

   typedef enum logic [1:0] {
      OP_READ    = 2'd0,
      OP_WRITE   = 2'd1,
      OP_DISCARD = 2'd2,
      OP_REBUILD = 2'd3
   } op_e;

   localparam logic [7:0] CMD_DISCARD = 8'h70;
   localparam logic [7:0] CMD_WRITE   = 8'h80;
   localparam logic [7:0] CMD_READ    = 8'hC0;
   localparam logic [7:0] CMD_REBUILD = 8'hE0;

   function automatic logic [7:0] cmd_of(op_e op);
      case (op)
         OP_WRITE:   return CMD_WRITE;
         OP_DISCARD: return CMD_DISCARD;
         OP_REBUILD: return CMD_REBUILD;
         default:    return CMD_READ;
      endcase
   endfunction

endpackage

// File: rtl/splt_cfg_check.sv
// Validates the stripe/target configuration and encodes the stripe log2.
module splt_cfg_check #(
   parameter int ADDR_W      = 32,
   parameter int TLOG_W      = 2,
   parameter int MAX_TGT_LOG = 2,
   parameter int SLOG_W      = 5
) (
   input  logic [ADDR_W-1:0] stripe,
   input  logic [TLOG_W-1:0] tlog,
   output logic              ok,
   output logic [SLOG_W-1:0] slog
);
   logic pow2;

   always_comb begin
      slog = '0;
      for (int i = 0; i < ADDR_W; i++) begin
         if (stripe[i]) slog = SLOG_W'(i);
      end
   end

   assign pow2 = (stripe != '0) && ((stripe & (stripe - ADDR_W'(1))) == '0);
   assign ok   = pow2 && (32'(tlog) <= MAX_TGT_LOG);

endmodule

// File: rtl/splt_stripe_map.sv
// Maps a linear byte address onto (target, per-target block address).
module splt_stripe_map #(
   parameter int ADDR_W      = 32,
   parameter int BLK_LOG     = 12,
   parameter int MAX_TGT_LOG = 2,
   parameter int TLOG_W      = 2,
   parameter int SLOG_W      = 5,
   parameter int TGT_W       = 2,
   parameter int LBA_W       = 20
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SLOG_W-1:0] slog,
   input  logic [TLOG_W-1:0] tlog,
   output logic [TGT_W-1:0]  tgt,
   output logic [LBA_W-1:0]  lba
);
   logic [ADDR_W-1:0] low_mask;
   logic [ADDR_W-1:0] tgt_addr;

   always_comb begin
      for (int i = 0; i < ADDR_W; i++) low_mask[i] = (i < int'(slog));
   end

   generate
      if (MAX_TGT_LOG == 0) begin : g_single
         assign tgt      = '0;
         assign tgt_addr = addr;
         logic unused_cfg;
         assign unused_cfg = ^{tlog, low_mask};
      end else begin : g_striped
         logic [TGT_W-1:0] tmask;
         always_comb begin
            for (int i = 0; i < TGT_W; i++) tmask[i] = (i < int'(tlog));
         end
         assign tgt      = TGT_W'(addr >> slog) & tmask;
         assign tgt_addr = ((addr >> tlog) & ~low_mask) | (addr & low_mask);
      end
   endgenerate

   assign lba = LBA_W'(tgt_addr >> BLK_LOG);

endmodule

// File: rtl/splt_piece.sv
// Sizes the next piece and packs the sector offset/count byte.
module splt_piece #(
   parameter int LEN_W    = 24,
   parameter int BLK_LOG  = 12,
   parameter int SECT_LOG = 9
) (
   input  logic [BLK_LOG-1:0] addr_lo,
   input  logic [LEN_W-1:0]   rem,
   input  logic               discard,
   output logic [LEN_W-1:0]   step,
   output logic               last,
   output logic [7:0]         sub
);
   localparam int SUB_W = BLK_LOG - SECT_LOG;
   localparam logic [BLK_LOG:0] BLK_BYTES = (BLK_LOG+1)'(1) << BLK_LOG;

   logic [BLK_LOG:0] room;
   logic [SUB_W-1:0] cnt;
   logic [SUB_W-1:0] off;

   assign room = discard ? BLK_BYTES : (BLK_BYTES - {1'b0, addr_lo});
   assign last = (rem <= LEN_W'(room));
   assign step = last ? rem : LEN_W'(room);
   assign cnt  = discard ? '0 : step[BLK_LOG-1:SECT_LOG];
   assign off  = discard ? '0 : addr_lo[BLK_LOG-1:SECT_LOG];
   assign sub  = {1'b0, cnt, 1'b0, off};

endmodule

// File: rtl/striped_req_splitter.sv
module striped_req_splitter
   import splt_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 24,
   parameter int BLK_LOG     = 12,
   parameter int SECT_LOG    = 9,
   parameter int MAX_TGT_LOG = 2,
   localparam int TLOG_W = (MAX_TGT_LOG > 0) ? $clog2(MAX_TGT_LOG + 1) : 1,
   localparam int TGT_W  = (MAX_TGT_LOG > 0) ? MAX_TGT_LOG : 1,
   localparam int LBA_W  = ADDR_W - BLK_LOG,
   localparam int SLOG_W = $clog2(ADDR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_stripe_bytes,
   input  logic [TLOG_W-1:0] cfg_tgt_log2,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [1:0]        req_op,
   output logic              req_err,
   output logic              dsc_valid,
   input  logic              dsc_ready,
   output logic [TGT_W-1:0]  dsc_tgt,
   output logic [LBA_W-1:0]  dsc_lba,
   output logic [7:0]        dsc_cmd,
   output logic [7:0]        dsc_sub,
   output logic              dsc_last
);
   generate
      if (BLK_LOG - SECT_LOG != 3) begin : g_bad_sub
         $error("sector field must be three bits wide");
      end
      if (LEN_W <= BLK_LOG) begin : g_bad_len
         $error("length must be wider than the block offset");
      end
      if (MAX_TGT_LOG >= LBA_W) begin : g_bad_tgt
         $error("too many targets for the address width");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] ADDR_SECT_MASK = ~ADDR_W'((1 << SECT_LOG) - 1);
   localparam logic [LEN_W-1:0]  LEN_SECT_MASK  = ~LEN_W'((1 << SECT_LOG) - 1);

   logic              busy;
   logic              err_q;
   logic [ADDR_W-1:0] cur_addr;
   logic [LEN_W-1:0]  rem;
   op_e               op_q;
   logic [SLOG_W-1:0] slog_q;
   logic [TLOG_W-1:0] tlog_q;

   logic              cfg_ok;
   logic [SLOG_W-1:0] cfg_slog;
   logic [LEN_W-1:0]  step;
   logic              piece_last;
   logic              accept;
   logic              fire;
   logic [ADDR_W-1:0] addr_in;
   logic [LEN_W-1:0]  len_in;

   splt_cfg_check #(
      .ADDR_W(ADDR_W), .TLOG_W(TLOG_W), .MAX_TGT_LOG(MAX_TGT_LOG), .SLOG_W(SLOG_W)
   ) u_cfg (
      .stripe(cfg_stripe_bytes), .tlog(cfg_tgt_log2), .ok(cfg_ok), .slog(cfg_slog)
   );

   splt_stripe_map #(
      .ADDR_W(ADDR_W), .BLK_LOG(BLK_LOG), .MAX_TGT_LOG(MAX_TGT_LOG), .TLOG_W(TLOG_W),
      .SLOG_W(SLOG_W), .TGT_W(TGT_W), .LBA_W(LBA_W)
   ) u_map (
      .addr(cur_addr), .slog(slog_q), .tlog(tlog_q), .tgt(dsc_tgt), .lba(dsc_lba)
   );

   splt_piece #(
      .LEN_W(LEN_W), .BLK_LOG(BLK_LOG), .SECT_LOG(SECT_LOG)
   ) u_piece (
      .addr_lo(cur_addr[BLK_LOG-1:0]), .rem(rem), .discard(op_q == OP_DISCARD),
      .step(step), .last(piece_last), .sub(dsc_sub)
   );

   assign addr_in   = req_addr & ADDR_SECT_MASK;
   assign len_in    = req_len & LEN_SECT_MASK;
   assign req_ready = ~busy;
   assign accept    = req_valid & ~busy;
   assign fire      = busy & dsc_ready;

   assign dsc_valid = busy;
   assign dsc_cmd   = cmd_of(op_q);
   assign dsc_last  = piece_last;
   assign req_err   = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         err_q    <= 1'b0;
         cur_addr <= '0;
         rem      <= '0;
         op_q     <= OP_READ;
         slog_q   <= '0;
         tlog_q   <= '0;
      end else begin
         err_q <= 1'b0;
         if (accept) begin
            if (!cfg_ok) begin
               err_q <= 1'b1;
            end else if (len_in != '0) begin
               busy     <= 1'b1;
               cur_addr <= addr_in;
               rem      <= len_in;
               op_q     <= op_e'(req_op);
               slog_q   <= cfg_slog;
               tlog_q   <= cfg_tgt_log2;
            end
         end else if (fire) begin
            cur_addr <= cur_addr + ADDR_W'(step);
            rem      <= rem - step;
            if (piece_last) busy <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/striped_req_splitter_chk.sv
module striped_req_splitter_chk #(
   parameter int TGT_W = 2,
   parameter int LBA_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             req_err,
   input logic             dsc_valid,
   input logic             dsc_ready,
   input logic [TGT_W-1:0] dsc_tgt,
   input logic [LBA_W-1:0] dsc_lba,
   input logic [7:0]       dsc_cmd,
   input logic [7:0]       dsc_sub,
   input logic             dsc_last
);
   // R9
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsc_valid && !dsc_ready |=> dsc_valid && $stable(dsc_tgt) && $stable(dsc_lba)
         && $stable(dsc_cmd) && $stable(dsc_sub) && $stable(dsc_last));

   // R7
   err_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> $past(req_valid && req_ready));

   // R7
   err_no_dsc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> !dsc_valid);

   // R8
   ready_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsc_valid && dsc_ready && dsc_last |=> req_ready && !dsc_valid);

   // R4
   discard_sub_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsc_valid && dsc_cmd == 8'h70 |-> dsc_sub == 8'h00);

   // R3
   sub_fits_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsc_valid |-> !dsc_sub[7] && !dsc_sub[3] &&
         (({1'b0, dsc_sub[2:0]} + ((dsc_sub[6:4] == 3'd0) ? 4'd8 : {1'b0, dsc_sub[6:4]})) <= 4'd8));

   // R1
   cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsc_valid |-> (dsc_cmd == 8'h70 || dsc_cmd == 8'h80 || dsc_cmd == 8'hC0 || dsc_cmd == 8'hE0));

endmodule

bind striped_req_splitter striped_req_splitter_chk #(.TGT_W(TGT_W), .LBA_W(LBA_W)) u_chk (.*);

// File: tb/striped_req_splitter_test.sv
`timescale 1ns/1ps
module striped_req_splitter_test;

   typedef struct packed {
      logic [31:0] addr;
      logic [23:0] len;
      logic [1:0]  op;
      logic [31:0] stripe;
      logic [1:0]  tl;
      logic [7:0]  n;
      logic [1:0]  tgt;
      logic [19:0] lba;
      logic [7:0]  sub;
      logic [7:0]  cmd;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_0000, 24'h1000, 2'd0, 32'h1000, 2'd2, 8'd1, 2'd0, 20'h0,    8'h00, 8'hC0},
      '{32'h0000_1200, 24'h2000, 2'd1, 32'h1000, 2'd2, 8'd3, 2'd1, 20'h0,    8'h71, 8'h80},
      '{32'h0000_8000, 24'h3000, 2'd2, 32'h2000, 2'd1, 8'd3, 2'd0, 20'h4,    8'h00, 8'h70},
      '{32'h0010_0E00, 24'h0400, 2'd3, 32'h1000, 2'd0, 8'd2, 2'd0, 20'h100,  8'h17, 8'hE0},
      '{32'h0000_56FF, 24'h04FF, 2'd0, 32'h4000, 2'd2, 8'd1, 2'd1, 20'h1,    8'h23, 8'hC0},
      '{32'h0003_0000, 24'h1000, 2'd1, 32'h8000, 2'd2, 8'd1, 2'd2, 20'h8,    8'h00, 8'h80},
      '{32'h0000_1000, 24'h1800, 2'd2, 32'h1000, 2'd1, 8'd2, 2'd1, 20'h0,    8'h00, 8'h70}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_stripe_bytes = 32'h1000;
   logic [1:0]  cfg_tgt_log2 = 2'd0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [23:0] req_len = '0;
   logic [1:0]  req_op = '0;
   logic        req_err;
   logic        dsc_valid;
   logic        dsc_ready = 1'b1;
   logic [1:0]  dsc_tgt;
   logic [19:0] dsc_lba;
   logic [7:0]  dsc_cmd;
   logic [7:0]  dsc_sub;
   logic        dsc_last;

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   striped_req_splitter uut (.*);

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic void ref_dsc(input logic [31:0] a, input logic [23:0] r, input logic [1:0] op,
                                   input logic [31:0] s, input logic [1:0] tl,
                                   output logic [1:0] tgt, output logic [19:0] lba,
                                   output logic [7:0] sub, output logic [7:0] cmd,
                                   output logic [23:0] step, output logic last);
      int sl = 0;
      logic [31:0] ta;
      logic [23:0] room;
      for (int i = 0; i < 32; i++) if (s[i]) sl = i;
      ta  = ((a >> tl) & ~(s - 32'd1)) | (a & (s - 32'd1));
      lba = ta[31:12];
      tgt = 2'((a >> sl) & ((32'd1 << tl) - 32'd1));
      if (op == 2'd2) begin
         step = (r < 24'h1000) ? r : 24'h1000;
         sub  = 8'h00;
      end else begin
         room = 24'h1000 - {12'h0, a[11:0]};
         step = (r < room) ? r : room;
         sub  = {1'b0, step[11:9], 1'b0, a[11:9]};
      end
      case (op)
         2'd1: cmd = 8'h80;
         2'd2: cmd = 8'h70;
         2'd3: cmd = 8'hE0;
         default: cmd = 8'hC0;
      endcase
      last = (step == r);
   endfunction

   task automatic send(input logic [31:0] a, input logic [23:0] l, input logic [1:0] op,
                       input logic [31:0] s, input logic [1:0] tl);
      @(negedge clk);
      req_addr = a; req_len = l; req_op = op;
      cfg_stripe_bytes = s; cfg_tgt_log2 = tl;
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic run_vec(input int idx, input vec_t v);
      logic [31:0] ma;
      logic [23:0] mr;
      logic [1:0]  e_tgt;
      logic [19:0] e_lba;
      logic [7:0]  e_sub, e_cmd;
      logic [23:0] e_step;
      logic        e_last;
      logic [19:0] p_lba;
      logic [7:0]  p_sub;
      bit          prev_stall = 1'b0;
      bit          tog = 1'b0;
      bit          rdy;
      int          n = 0;
      int          guard = 0;
      ma = v.addr & ~32'h1FF;
      mr = v.len & ~24'h1FF;
      send(v.addr, v.len, v.op, v.stripe, v.tl);
      // R10: scramble configuration while the request is in flight
      cfg_stripe_bytes = 32'h0002_0000;
      cfg_tgt_log2 = (v.tl == 2'd0) ? 2'd2 : 2'd0;
      while (mr != 0 && guard < 64) begin
         guard++;
         rdy = (idx % 2 == 1) ? tog : 1'b1;
         tog = ~tog;
         dsc_ready = rdy;
         ref_dsc(ma, mr, v.op, v.stripe, v.tl, e_tgt, e_lba, e_sub, e_cmd, e_step, e_last);
         chk(dsc_valid == 1'b1, "R8 valid during split", 64'(dsc_valid), 64'd1);
         chk(req_ready == 1'b0, "R8 ready low while busy", 64'(req_ready), 64'd0);
         chk(dsc_tgt == e_tgt, "R5 target (R10 cfg held)", 64'(dsc_tgt), 64'(e_tgt));
         chk(dsc_lba == e_lba, "R6 block address (R10 cfg held)", 64'(dsc_lba), 64'(e_lba));
         chk(dsc_sub == e_sub, (v.op == 2'd2) ? "R4 discard sub" : "R3 sub byte", 64'(dsc_sub), 64'(e_sub));
         chk(dsc_cmd == e_cmd, "R1 command", 64'(dsc_cmd), 64'(e_cmd));
         chk(dsc_last == e_last, "R2 last flag", 64'(dsc_last), 64'(e_last));
         if (prev_stall)
            chk(dsc_lba == p_lba && dsc_sub == p_sub, "R9 held under stall",
                64'({dsc_lba, dsc_sub}), 64'({p_lba, p_sub}));
         if (n == 0 && !prev_stall) begin
            chk(dsc_tgt == v.tgt, "R5 table target", 64'(dsc_tgt), 64'(v.tgt));
            chk(dsc_lba == v.lba, "R6 table block address", 64'(dsc_lba), 64'(v.lba));
            chk(dsc_sub == v.sub, "R3 table sub byte", 64'(dsc_sub), 64'(v.sub));
            chk(dsc_cmd == v.cmd, "R1 table command", 64'(dsc_cmd), 64'(v.cmd));
         end
         p_lba = dsc_lba;
         p_sub = dsc_sub;
         prev_stall = !rdy;
         if (rdy) begin
            ma = ma + 32'(e_step);
            mr = mr - e_step;
            n++;
         end
         @(negedge clk);
      end
      dsc_ready = 1'b1;
      chk(n == int'(v.n), "R2 piece count", 64'(n), 64'(v.n));
      chk(!dsc_valid && req_ready, "R8 idle after last", 64'({dsc_valid, req_ready}), 64'b01);
   endtask

   task automatic bad_cfg(input logic [31:0] s, input logic [1:0] tl);
      send(32'h2000, 24'h1000, 2'd0, s, tl);
      chk(req_err == 1'b1, "R7 error pulse", 64'(req_err), 64'd1);
      chk(!dsc_valid, "R7 no descriptor", 64'(dsc_valid), 64'd0);
      @(negedge clk);
      chk(req_err == 1'b0 && !dsc_valid && req_ready, "R7 single-cycle error",
          64'({req_err, dsc_valid, req_ready}), 64'b001);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(req_ready == 1'b1 && !dsc_valid && !req_err, "R11 reset state",
          64'({req_ready, dsc_valid, req_err}), 64'b100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && !dsc_valid && !req_err, "R11 after release",
          64'({req_ready, dsc_valid, req_err}), 64'b100);

      for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

      bad_cfg(32'h0000_3000, 2'd1);
      bad_cfg(32'h0000_0000, 2'd0);
      bad_cfg(32'h0000_1000, 2'd3);

      // R8: zero-length request
      send(32'h4000, 24'h0000, 2'd1, 32'h1000, 2'd1);
      chk(!dsc_valid && req_ready && !req_err, "R8 zero length",
          64'({dsc_valid, req_ready, req_err}), 64'b010);
      // R8: length below one sector rounds to zero
      send(32'h4000, 24'h01FF, 2'd0, 32'h1000, 2'd1);
      chk(!dsc_valid && req_ready && !req_err, "R2 sub-sector length ignored",
          64'({dsc_valid, req_ready, req_err}), 64'b010);

      run_vec(1, VECS[1]);

      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

endmodule